// File: doc/BRIEF.md
# Audio DAC Serial Mode Controller

This block sets up an audio DAC over a three-wire control port: a latch line, a serial clock and a serial data line. When system reset is released it holds the DAC reset line low for a fixed number of cycles, then releases it. In the cycle after that it captures seven active-low strap pins, which are configuration jumpers. From them it builds two configuration words and shifts both out. After that it sends attenuation words without end, each one carrying the current 8-bit level input.

Every word has 16 bits and goes out most significant bit first. The upper byte addresses a DAC register and the lower byte holds the data. Data changes while the serial clock is low, and the DAC samples it on the rising edge. The latch line marks the last bit of a word. It falls before that bit's rising edge and rises again while the clock is still high. A busy output tells the rest of the chip when the DAC configuration is complete.

Top module: `dac_cfg_ctrl`

## Requirements
- R1: While `rst` is high, `ctl_latch` is 1, `ctl_sclk` is 0, `ctl_sdata` is 0, `dac_rst_n` is 0 and `busy` is 1.
- R2: After `rst` falls, `dac_rst_n` stays 0 for exactly RST_CYC cycles and is 1 from then on. While it is 0 the serial lines stay idle (latch 1, clock 0).
- R3: `strap_n` is captured once, in the single cycle that follows the DAC reset pulse. Later changes of `strap_n` do not alter any word sent.
- R4: Each word is 16 bits, most significant bit first. Each bit lasts HALF_DIV cycles with `ctl_sclk` low, then HALF_DIV cycles with `ctl_sclk` high. `ctl_sdata` holds the bit value for all 2*HALF_DIV cycles.
- R5: `ctl_latch` is 0 during the low half of bit 15 (the last bit) and during the first cycle of that bit's high half. It is 1 at every other time.
- R6: The first word has upper byte 0x04. Its data byte is zero except for these bits: bit 3 = strap 0 low, bit 4 = strap 1 low, bit 1 = strap 3 low.
- R7: The second word has upper byte 0x06. Its data byte starts from 0x04, and these bits are set as well: bit 0 = strap 2 low, bit 6 = strap 4 low, bit 7 = strap 5 low, bit 3 = strap 6 low.
- R8: Every later word has upper byte 0x01 and the captured level as its data byte, with no end. Exactly one idle cycle (latch 1, clock 0, data 0) comes before each word.
- R9: `level` is sampled in the idle cycle that starts a word. Changes of `level` during that word's 32*HALF_DIV shift cycles do not affect it.
- R10: `busy` is 1 from reset until the last cycle of the second word, inclusive. It is 0 from the idle cycle that starts the first attenuation word onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_n | input | 7 | Active-low configuration straps, 0 = asserted |
| level | input | 8 | Attenuation level for the next attenuation word |
| dac_rst_n | output | 1 | DAC reset, active low |
| ctl_latch | output | 1 | Control-port latch line, idles high |
| ctl_sclk | output | 1 | Control-port serial clock |
| ctl_sdata | output | 1 | Control-port serial data |
| busy | output | 1 | High until both configuration words are sent |

## Verification
The assertions assume that HALF_DIV is at least 2. They also assume that `rst` is held for at least one clock edge. Under those conditions the latch can rise during the first high cycle of bit 15 and is back high before that clock falls. Strap and level inputs are treated as fully asynchronous to the word timing. The bench relies on this: it changes `level` on every cycle and changes `strap_n` on every cycle after capture. It also drives reset again in the middle of a word, so the outputs must snap back to the idle state from any point in the sequence.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;

    localparam int WORD_W  = 16;
    localparam int DATA_W  = 8;
    localparam int STRAP_N = 7;

    localparam logic [7:0] ADDR_CFG_A = 8'h04;
    localparam logic [7:0] ADDR_CFG_B = 8'h06;
    localparam logic [7:0] ADDR_ATT   = 8'h01;
    localparam logic [7:0] CFG_B_BASE = 8'h04;

    typedef struct packed {
        logic [7:0]        addr;
        logic [DATA_W-1:0] data;
    } ctl_word_t;

    typedef enum logic [2:0] {
        SEQ_RST,
        SEQ_SAMP,
        SEQ_CFGA,
        SEQ_CFGB,
        SEQ_ATT
    } seq_t;

    typedef enum logic {
        PH_LO,
        PH_HI
    } ph_t;

    function automatic ctl_word_t att_word(input logic [DATA_W-1:0] lvl);
        ctl_word_t w;
        w.addr = ADDR_ATT;
        w.data = lvl;
        return w;
    endfunction

endpackage

// File: rtl/dac_cfg_words.sv
module dac_cfg_words
    import dac_cfg_pkg::*;
(
    input  logic [STRAP_N-1:0] strap_q,
    output ctl_word_t          word_a,
    output ctl_word_t          word_b
);
    logic [STRAP_N-1:0] on;
    assign on = ~strap_q;

    always_comb begin
        word_a.addr    = ADDR_CFG_A;
        word_a.data    = '0;
        word_a.data[3] = on[0];
        word_a.data[4] = on[1];
        word_a.data[1] = on[3];

        word_b.addr    = ADDR_CFG_B;
        word_b.data    = CFG_B_BASE;
        word_b.data[0] = on[2];
        word_b.data[6] = on[4];
        word_b.data[7] = on[5];
        word_b.data[3] = on[6];
    end
endmodule

// File: rtl/dac_cfg_shift.sv
module dac_cfg_shift
    import dac_cfg_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              idle,
    output logic              done,
    output logic              latch_o,
    output logic              sclk_o,
    output logic              sdata_o
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam int BW = $clog2(WORD_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(WORD_W - 1);

    logic              active;
    ph_t               ph;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bidx;
    logic [WORD_W-1:0] shreg;
    logic              tick;

    assign tick = active && (cnt == CNT_LAST);
    assign done = tick && (ph == PH_HI) && (bidx == BIT_LAST);
    assign idle = !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= PH_LO;
            cnt    <= '0;
            bidx   <= '0;
            shreg  <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                shreg  <= word;
                cnt    <= '0;
                bidx   <= '0;
                ph     <= PH_LO;
            end
        end else if (tick) begin
            cnt <= '0;
            if (ph == PH_LO) begin
                ph <= PH_HI;
            end else if (done) begin
                active <= 1'b0;
                ph     <= PH_LO;
            end else begin
                bidx  <= bidx + 1'b1;
                shreg <= {shreg[WORD_W-2:0], 1'b0};
                ph    <= PH_LO;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sclk_o  = active && (ph == PH_HI);
    assign sdata_o = active && shreg[WORD_W-1];
    assign latch_o = !(active && (bidx == BIT_LAST) &&
                       ((ph == PH_LO) || (cnt == '0)));

    // R4: data is frozen while the serial clock is high
    a_r4_data_held_high: assert property (@(posedge clk) disable iff (rst)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    // R5: latch falls only while the clock is low
    a_r5_latch_falls_low: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_o) |-> !sclk_o);

    // R5: latch rises only while the clock is still high
    a_r5_latch_rises_high: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_o) |-> sclk_o);
endmodule

// File: rtl/dac_cfg_ctrl.sv
module dac_cfg_ctrl
    import dac_cfg_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int RST_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_N-1:0] strap_n,
    input  logic [DATA_W-1:0]  level,
    output logic               dac_rst_n,
    output logic               ctl_latch,
    output logic               ctl_sclk,
    output logic               ctl_sdata,
    output logic               busy
);
    localparam int RW = $clog2(RST_CYC + 1);
    localparam logic [RW-1:0] RCNT_LAST = RW'(RST_CYC - 1);

    seq_t               seq_q;
    logic [RW-1:0]      rcnt;
    logic [STRAP_N-1:0] strap_q;
    ctl_word_t          word_a, word_b, word_sel;
    logic               sh_idle, sh_done, start;

    dac_cfg_words u_words (
        .strap_q (strap_q),
        .word_a  (word_a),
        .word_b  (word_b)
    );

    always_comb begin
        case (seq_q)
            SEQ_CFGA: word_sel = word_a;
            SEQ_CFGB: word_sel = word_b;
            default:  word_sel = att_word(level);
        endcase
    end

    assign start = sh_idle &&
                   (seq_q == SEQ_CFGA || seq_q == SEQ_CFGB || seq_q == SEQ_ATT);

    dac_cfg_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .word    (word_sel),
        .idle    (sh_idle),
        .done    (sh_done),
        .latch_o (ctl_latch),
        .sclk_o  (ctl_sclk),
        .sdata_o (ctl_sdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q   <= SEQ_RST;
            rcnt    <= '0;
            strap_q <= '1;
        end else begin
            case (seq_q)
                SEQ_RST: begin
                    if (rcnt == RCNT_LAST) seq_q <= SEQ_SAMP;
                    else                   rcnt  <= rcnt + 1'b1;
                end
                SEQ_SAMP: begin
                    strap_q <= strap_n;
                    seq_q   <= SEQ_CFGA;
                end
                SEQ_CFGA: if (sh_done) seq_q <= SEQ_CFGB;
                SEQ_CFGB: if (sh_done) seq_q <= SEQ_ATT;
                default:  seq_q <= SEQ_ATT;
            endcase
        end
    end

    assign dac_rst_n = (seq_q != SEQ_RST);
    assign busy      = (seq_q != SEQ_ATT);

    // R2: serial port stays idle during the DAC reset pulse
    a_r2_quiet_in_pulse: assert property (@(posedge clk) disable iff (rst)
        !dac_rst_n |-> (ctl_latch && !ctl_sclk));

    // R3: captured straps never change once configuration writes began
    a_r3_straps_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(seq_q) == SEQ_CFGA || $past(seq_q) == SEQ_CFGB ||
         $past(seq_q) == SEQ_ATT) |-> $stable(strap_q));

    // R10: once busy drops it stays low
    a_r10_busy_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(!busy) |-> !busy);

    // R2: DAC reset, once released, is never reasserted
    a_r2_release_sticky: assert property (@(posedge clk) disable iff (rst)
        $past(dac_rst_n) |-> dac_rst_n);
endmodule

// File: tb/dac_cfg_ctrl_test.sv
`timescale 1ns/1ps
module dac_cfg_ctrl_test;
    localparam int HALF = 3;
    localparam int RSTC = 5;
    localparam int WLEN = 32 * HALF + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] strap_n = 7'h7f;
    logic [7:0] level = 8'h00;
    logic       dac_rst_n, ctl_latch, ctl_sclk, ctl_sdata, busy;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] lvq[$];
    logic [6:0] s_cap;

    always #2 clk = ~clk;

    dac_cfg_ctrl #(.HALF_DIV(HALF), .RST_CYC(RSTC)) uut (
        .clk       (clk),
        .rst       (rst),
        .strap_n   (strap_n),
        .level     (level),
        .dac_rst_n (dac_rst_n),
        .ctl_latch (ctl_latch),
        .ctl_sclk  (ctl_sclk),
        .ctl_sdata (ctl_sdata),
        .busy      (busy)
    );

    task automatic chk(input string tag, input int t, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: got %b expected %b", tag, t, act, exp);
        end
    endtask

    function automatic logic [15:0] word_for(input int k);
        logic [7:0] d;
        if (k == 0) begin
            d = 8'h00;
            if (!s_cap[0]) d = d | 8'h08;
            if (!s_cap[1]) d = d | 8'h10;
            if (!s_cap[3]) d = d | 8'h02;
            return {8'h04, d};
        end else if (k == 1) begin
            d = 8'h04;
            if (!s_cap[2]) d = d | 8'h01;
            if (!s_cap[4]) d = d | 8'h40;
            if (!s_cap[5]) d = d | 8'h80;
            if (!s_cap[6]) d = d | 8'h08;
            return {8'h06, d};
        end
        return {8'h01, lvq[k-2]};
    endfunction

    task automatic run(input logic [6:0] pat, input int ncyc);
        rst = 1'b1;
        strap_n = pat;
        lvq.delete();
        repeat (3) begin
            @(negedge clk);
            chk("R1 latch", -1, ctl_latch, 1'b1);
            chk("R1 sclk",  -1, ctl_sclk,  1'b0);
            chk("R1 sdata", -1, ctl_sdata, 1'b0);
            chk("R1 rst_n", -1, dac_rst_n, 1'b0);
            chk("R1 busy",  -1, busy,      1'b1);
        end
        rst = 1'b0;
        for (int t = 0; t < ncyc; t++) begin
            logic e_rn, e_l, e_c, e_d, e_b;
            int k;
            int p;
            if (t > 0) @(negedge clk);
            k = -1;
            p = -1;
            e_rn = (t >= RSTC);
            e_l = 1'b1; e_c = 1'b0; e_d = 1'b0; e_b = 1'b1;
            if (t > RSTC) begin
                k = (t - RSTC - 1) / WLEN;
                p = (t - RSTC - 1) % WLEN;
                e_b = (k < 2);
                if (p > 0) begin
                    int a, b, w;
                    logic [15:0] wd;
                    a = p - 1;
                    b = a / (2 * HALF);
                    w = a % (2 * HALF);
                    wd = word_for(k);
                    e_c = (w >= HALF);
                    e_d = wd[15 - b];
                    e_l = !(b == 15 && w <= HALF);
                end
            end
            chk("R2 dac_rst_n", t, dac_rst_n, e_rn);
            chk("R4 sclk",      t, ctl_sclk,  e_c);
            chk("R5 latch",     t, ctl_latch, e_l);
            chk("R10 busy",     t, busy,      e_b);
            if (k == 0)      chk("R6 R3 sdata", t, ctl_sdata, e_d);
            else if (k == 1) chk("R7 R3 sdata", t, ctl_sdata, e_d);
            else             chk("R8 R9 sdata", t, ctl_sdata, e_d);
            // drive inputs for the edge that ends this cycle
            if (t == RSTC) s_cap = pat;
            else if (t > RSTC) strap_n = strap_n + 7'd37;
            level = 8'($urandom);
            if (k >= 2 && p == 0) lvq.push_back(level);
        end
    endtask

    initial begin
        run(7'b1111111, RSTC + 1 + 4 * WLEN + 40);
        run(7'b0000000, RSTC + 1 + 5 * WLEN + 10);
        run(7'b1010101, RSTC + 1 + 3 * WLEN + 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule